// File: doc/BRIEF.md
# Processor Clock Source Selector

This block picks the clock that drives a processor core. There are three sources: the 1x input clock, a faster clock from a frequency synthesizer, and a slow internal clock used to save power. Software writes two select bits, one for the synthesizer and one for the slow clock. The block hands the processor clock from one source to the next without glitches, and it drives the power-down line of the synthesizer.

The slow select bit takes priority over the synthesizer select bit. When both bits are set, the slow clock drives the processor and the synthesizer stays powered and running, so that it can take over quickly later. The block does not hand over to the synthesizer until the synthesizer reports lock. When software deselects the synthesizer while it is driving the processor, the processor clock first returns to the 1x clock, and only after that is the synthesizer powered down. Reset returns the block to the 1x clock, with the synthesizer deselected and powered down.

Top module: `clk_source_sel`

## Requirements
- R1: After reset, `activeSrc` reads 2'b00 (1x clock), `synthPowerDown` is high, and `procClk` runs at the `refClk` rate.
- R2: A write with `wrData[0]` (the synthesizer select bit) set drives `synthPowerDown` low at the first `refClk` rising edge after the write.
- R3: While the synthesizer is selected, the slow clock is not selected and `synthLock` is low, the 1x clock stays the source and `synthPowerDown` stays low. Once lock is reported, the synthesizer becomes the source.
- R4: While the synthesizer is the source, `procClk` runs at the synthesizer rate and `synthPowerDown` is low.
- R5: When `wrData[1]` (the slow select bit) is set, the slow clock drives `procClk`, whatever the value of bit 0.
- R6: While both select bits are set, `synthPowerDown` stays low.
- R7: After the synthesizer is deselected while it is the source, the 1x clock becomes the source before `synthPowerDown` rises.
- R8: A handover never puts a pulse on `procClk` that is narrower than the shortest half period of any source, and at most one source is enabled at any time.
- R9: `activeSrc` shows the settled source: 2'b00 for the 1x clock, 2'b01 for the synthesizer, 2'b10 for the slow clock, and 2'b11 while a handover is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | 1x input clock; also clocks the control logic |
| synthClk | input | 1 | Output of the frequency synthesizer |
| slowClk | input | 1 | Internal slow clock for low-power operation |
| synthLock | input | 1 | Lock indication from the synthesizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the select bits |
| wrData | input | 2 | Bit 0 selects the synthesizer, bit 1 selects the slow clock |
| procClk | output | 1 | Selected processor clock, free of glitches |
| synthPowerDown | output | 1 | High powers the synthesizer down |
| activeSrc | output | 2 | Settled source code (see R9) |

## Verification
The hardest state to reach is the one where the power-down decision meets the handover. The synthesizer is driving the processor and is then deselected, and power-down must wait until the 1x clock has taken over. The bench reaches this state on purpose. It models the synthesizer so that its clock stops and its lock drops while it is powered down, which means an early power-down shows up at the ports as a stuck or dead `procClk`. It also holds lock low to show that the handover waits for lock. A sweep over every ordered pair of select codes checks the source code, the power-down line and the measured `procClk` rate. Throughout the sweep, a monitor records the narrowest `procClk` pulse.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_REF   = 0;
  localparam int SRC_SYNTH = 1;
  localparam int SRC_SLOW  = 2;
  localparam int SEL_W     = 2;
  localparam int SEL_SYNTH = 0;
  localparam int SEL_SLOW  = 1;

  typedef enum logic [1:0] {
    ACT_REF   = 2'b00,
    ACT_SYNTH = 2'b01,
    ACT_SLOW  = 2'b10,
    ACT_NONE  = 2'b11
  } act_e;

  // strobes from control to the gating datapath
  typedef struct packed {
    logic wantSlow;
    logic wantSynth;
    logic wantRef;
  } want_t;
endpackage

// File: rtl/clk_sel_path.sv
module clk_sel_path
  import clk_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               synthClk,
  input  logic               slowClk,
  input  logic               rst_n,
  input  want_t              want,
  output logic               procClk,
  output logic [NUM_SRC-1:0] srcEn
);
  logic [NUM_SRC-1:0] srcClk;
  logic [NUM_SRC-1:0] wantVec;
  logic [NUM_SRC-1:0] gated;

  assign srcClk  = {slowClk, synthClk, refClk};
  assign wantVec = {want.wantSlow, want.wantSynth, want.wantRef};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_branch
    localparam logic RST_ON = (i == SRC_REF);
    logic [SYNC_STAGES-1:0] chainQ;
    logic                   enQ;
    logic                   othersOn;
    logic                   armIn;

    assign othersOn = |(srcEn & ~(NUM_SRC'(1) << i));
    assign armIn    = wantVec[i] & ~othersOn;

    // two-flop (or deeper) synchronizer in this source's own domain
    always_ff @(posedge srcClk[i] or negedge rst_n) begin
      if (!rst_n) chainQ <= {SYNC_STAGES{RST_ON}};
      else        chainQ <= {chainQ[SYNC_STAGES-2:0], armIn};
    end

    // enable changes only while this clock is low
    always_ff @(negedge srcClk[i] or negedge rst_n) begin
      if (!rst_n) enQ <= RST_ON;
      else        enQ <= chainQ[SYNC_STAGES-1];
    end

    assign srcEn[i] = enQ;
    assign gated[i] = srcClk[i] & enQ;
  end

  assign procClk = |gated;

  p_one_branch_r8: assert property (@(posedge refClk) disable iff (!rst_n)
    $onehot0(srcEn));
endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PD_HOLD     = 8
) (
  input  logic               refClk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrData,
  input  logic               synthLock,
  input  logic [NUM_SRC-1:0] srcEn,
  output want_t              want,
  output logic               synthPowerDown,
  output act_e               activeSrc
);
  localparam int HOLD_W = $clog2(PD_HOLD + 1);

  logic [SEL_W-1:0]       selQ, selNext;
  logic [SYNC_STAGES-1:0] lockQ;
  logic                   lockSeen;
  logic [NUM_SRC-1:0]     enSeen;
  logic [NUM_SRC-1:0]     wantVec;
  want_t                  target;
  logic                   settledOff;
  logic [HOLD_W-1:0]      holdCnt;

  assign selNext = wrEn ? wrData : selQ;

  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) selQ <= '0;
    else        selQ <= selNext;
  end

  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) lockQ <= '0;
    else        lockQ <= {lockQ[SYNC_STAGES-2:0], synthLock};
  end
  assign lockSeen = lockQ[SYNC_STAGES-1];

  // bring each branch enable back into the control domain
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en_sync
    localparam logic RST_ON = (i == SRC_REF);
    logic [SYNC_STAGES-1:0] enQ;
    always_ff @(posedge refClk or negedge rst_n) begin
      if (!rst_n) enQ <= {SYNC_STAGES{RST_ON}};
      else        enQ <= {enQ[SYNC_STAGES-2:0], srcEn[i]};
    end
    assign enSeen[i] = enQ[SYNC_STAGES-1];
  end

  // slow select overrides; synthesizer only once lock is seen
  always_comb begin
    target = '0;
    if (selQ[SEL_SLOW])                     target.wantSlow  = 1'b1;
    else if (selQ[SEL_SYNTH] && lockSeen)   target.wantSynth = 1'b1;
    else                                    target.wantRef   = 1'b1;
  end

  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) want <= '{wantSlow: 1'b0, wantSynth: 1'b0, wantRef: 1'b1};
    else        want <= target;
  end

  assign wantVec    = {want.wantSlow, want.wantSynth, want.wantRef};
  assign settledOff = (enSeen == wantVec) && !enSeen[SRC_SYNTH] && !want.wantSynth;

  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n)                         holdCnt <= '0;
    else if (!settledOff)               holdCnt <= '0;
    else if (holdCnt != HOLD_W'(PD_HOLD)) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n)                              synthPowerDown <= 1'b1;
    else if (selNext[SEL_SYNTH])             synthPowerDown <= 1'b0;
    else if (holdCnt == HOLD_W'(PD_HOLD))    synthPowerDown <= 1'b1;
  end

  always_comb begin
    unique case (enSeen)
      3'b001:  activeSrc = ACT_REF;
      3'b010:  activeSrc = ACT_SYNTH;
      3'b100:  activeSrc = ACT_SLOW;
      default: activeSrc = ACT_NONE;
    endcase
  end

  p_sel_wakes_r2: assert property (@(posedge refClk) disable iff (!rst_n)
    (wrEn && wrData[SEL_SYNTH]) |=> !synthPowerDown);
  p_synth_powered_r4: assert property (@(posedge refClk) disable iff (!rst_n)
    (activeSrc == ACT_SYNTH) |-> !synthPowerDown);
  p_both_keep_pwr_r6: assert property (@(posedge refClk) disable iff (!rst_n)
    (selQ == 2'b11) |-> !synthPowerDown);
  p_pd_after_handback_r7: assert property (@(posedge refClk) disable iff (!rst_n)
    $rose(synthPowerDown) |-> (activeSrc == ACT_REF || activeSrc == ACT_SLOW));
endmodule

// File: rtl/clk_source_sel.sv
module clk_source_sel
  import clk_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PD_HOLD     = 8
) (
  input  logic       refClk,
  input  logic       synthClk,
  input  logic       slowClk,
  input  logic       synthLock,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrData,
  output logic       procClk,
  output logic       synthPowerDown,
  output logic [1:0] activeSrc
);
  want_t              want;
  logic [NUM_SRC-1:0] srcEn;
  act_e               act;

  clk_sel_ctrl #(.SYNC_STAGES(SYNC_STAGES), .PD_HOLD(PD_HOLD)) ctrl_i (
    .refClk(refClk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .synthLock(synthLock), .srcEn(srcEn), .want(want),
    .synthPowerDown(synthPowerDown), .activeSrc(act)
  );

  clk_sel_path #(.SYNC_STAGES(SYNC_STAGES)) path_i (
    .refClk(refClk), .synthClk(synthClk), .slowClk(slowClk), .rst_n(rst_n),
    .want(want), .procClk(procClk), .srcEn(srcEn)
  );

  assign activeSrc = act;
endmodule

// File: tb/clk_source_sel_tb_top.sv
`timescale 1ns/1ps
module clk_source_sel_tb_top;
  logic refClk = 0, synthClk = 0, slowClk = 0;
  logic rst_n = 0, wrEn = 0, lockAllow = 0;
  logic [1:0] wrData = 0;
  logic procClk, synthPowerDown, synthLock;
  logic [1:0] activeSrc;

  int checks = 0, fails = 0, edgeCnt = 0, badPd = 0;
  realtime lastEdge = 0, minPulse = 1000.0;

  clk_source_sel dut_i (
    .refClk(refClk), .synthClk(synthClk), .slowClk(slowClk), .synthLock(synthLock),
    .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .procClk(procClk),
    .synthPowerDown(synthPowerDown), .activeSrc(activeSrc)
  );

  // 125 MHz ref, synthesizer 4x (stops when powered down), slow at ref/4
  always #4 refClk = ~refClk;
  always #16 slowClk = ~slowClk;
  always #1 synthClk = synthPowerDown ? 1'b0 : ~synthClk;
  assign synthLock = lockAllow & ~synthPowerDown;

  always @(posedge procClk) edgeCnt++;
  always @(procClk) begin
    if (rst_n && ($realtime - lastEdge) < minPulse) minPulse = $realtime - lastEdge;
    lastEdge = $realtime;
  end
  always @(negedge refClk) if (rst_n && synthPowerDown && activeSrc == 2'b01) badPd++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkNear(string req, int act, int exp, int tol);
    checks++;
    if (act < exp - tol || act > exp + tol) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitRef(int n);
    for (int k = 0; k < n; k++) @(negedge refClk);
  endtask

  task automatic writeSel(logic [1:0] v);
    @(negedge refClk); wrEn = 1; wrData = v;
    @(negedge refClk); wrEn = 0;
  endtask

  function automatic int rateFor(int act);
    return act == 1 ? 256 : (act == 2 ? 16 : 64);
  endfunction

  task automatic measure(string req, int exp);
    int start;
    start = edgeCnt;
    waitRef(64);
    checkNear(req, edgeCnt - start, exp, 2);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitRef(3);
    rst_n = 1;
    waitRef(4);
    check("R1 active", activeSrc, 0);
    check("R1 powerdown", synthPowerDown, 1);
    measure("R1 rate", 64);

    // lock held low: synth selected but 1x clock stays
    writeSel(2'b01);
    check("R2 powerdown low after write", synthPowerDown, 0);
    waitRef(80);
    check("R3 no lock active", activeSrc, 0);
    check("R3 no lock powerdown", synthPowerDown, 0);
    measure("R3 no lock rate", 64);
    lockAllow = 1;
    waitRef(80);
    check("R3 locked active R9", activeSrc, 1);
    measure("R4 synth rate", 256);

    // deselect while synth drives
    badPd = 0;
    writeSel(2'b00);
    waitRef(80);
    check("R7 early powerdown events", badPd, 0);
    check("R7 active", activeSrc, 0);
    check("R7 powerdown", synthPowerDown, 1);
    measure("R7 rate", 64);

    // sweep every ordered pair of select codes
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        int expAct;
        writeSel(2'(f));
        waitRef(80);
        writeSel(2'(t));
        waitRef(80);
        expAct = t[1] ? 2 : (t[0] ? 1 : 0);
        check($sformatf("R5 R9 active %0d->%0d", f, t), activeSrc, expAct);
        check($sformatf("R4 R6 powerdown %0d->%0d", f, t), synthPowerDown, t[0] ? 0 : 1);
        measure($sformatf("R4 R5 rate %0d->%0d", f, t), rateFor(expAct));
      end
    end
    check("R7 sweep early powerdown events", badPd, 0);
    checks++;
    if (minPulse < 0.9) begin
      fails++;
      $display("FAIL R8 min pulse actual=%0f expected>=0.9", minPulse);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule